// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This block produces a gated configuration clock on `dclk_o` as a finite burst of pulses. A requester names a pulse count, the block plays out exactly that many full clock periods (high for `HALF_DIV` system cycles, then low for `HALF_DIV` cycles), and then raises a completion flag. Between bursts the clock output stays low.

Two requesters can start a burst. A host uses a small 32-bit word-addressed register window: writing the count register starts a burst, and a status register holds a sticky done bit that is cleared by writing 1 to it. An on-chip sequencer uses a start/count strobe and receives a one-cycle done pulse when a burst it launched finishes. While a burst runs, further start requests from either side are dropped.

Top module: `cfg_clk_burst`

## Requirements
- R1: A write to address 0x08 while idle launches a burst of exactly N pulses on `dclk_o`, where N is `reg_wdata_i[CNT_W-1:0]`.
- R2: Every pulse is high for `HALF_DIV` clock cycles and then low for `HALF_DIV` cycles; the first high phase begins in the cycle after the accepting edge.
- R3: Bit 0 of address 0x0C (done) becomes 1 at the edge that ends the low phase of the last pulse and stays 1 until it is cleared.
- R4: Writing address 0x0C with bit 0 = 1 clears done; writing it with bit 0 = 0 leaves done unchanged; if a burst finishes in the same cycle as a clear, done ends up 1.
- R5: A start with a count of 0 sets done at the accepting edge, raises no pulse and leaves `busy_o` low.
- R6: A start from either requester while `busy_o` is high is dropped: the running burst keeps its pulse count and the count readback keeps its value.
- R7: `dclk_o` is 0 whenever `busy_o` is 0.
- R8: Reading 0x08 returns the last accepted count zero-extended, reading 0x0C returns done in bit 0 with all other bits 0, and every other address reads 0.
- R9: When idle, `seq_start_i` launches a burst of `seq_count_i` pulses; when that burst finishes `seq_done_o` is high for one cycle at the same edge done is set; a count register write in the same cycle wins and the sequencer start is dropped.
- R10: `busy_o` is 1 from the edge that accepts a nonzero start until the edge that ends the last low phase.
- R11: With the default 12-bit count, a burst of 2047 pulses is produced in full.
- R12: After reset `dclk_o`, `busy_o`, `seq_done_o`, done and the count readback are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | AW (8) | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DW (32) | Register write data |
| reg_rdata_o | output | DW (32) | Register read data for `reg_addr_i`, combinational |
| seq_start_i | input | 1 | Sequencer start strobe |
| seq_count_i | input | CNT_W (12) | Sequencer pulse count |
| seq_done_o | output | 1 | One-cycle pulse when a sequencer burst completes |
| busy_o | output | 1 | Burst in progress |
| dclk_o | output | 1 | Gated configuration clock |

## Verification
A wrong remaining-pulse count or phase counter shows as an extra or missing rising edge on `dclk_o` or a high/low phase of the wrong length, visible within one half period of the fault; the per-clock comparison against a time-based model catches it at that cycle. A wrong done or ownership bit shows on the status readback or `seq_done_o` at the edge the burst ends, and a start that is wrongly accepted mid-burst shows immediately as a changed count readback and later as a longer burst.

// File: rtl/cfg_clk_pkg.sv
package cfg_clk_pkg;
  localparam int unsigned OFS_COUNT  = 'h08;
  localparam int unsigned OFS_STATUS = 'h0C;
endpackage

// File: rtl/cfg_clk_regif.sv
module cfg_clk_regif #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_we_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             done_set_i,
  output logic             reg_go_o,
  output logic [CNT_W-1:0] reg_cnt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  import cfg_clk_pkg::*;

  localparam logic [AW-1:0] A_CNT  = AW'(OFS_COUNT);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STATUS);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             clr_w;
  logic             unused_wdata;

  assign reg_go_o     = reg_we_i && (reg_addr_i == A_CNT);
  assign reg_cnt_o    = reg_wdata_i[CNT_W-1:0];
  assign clr_w        = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[0];
  assign unused_wdata = ^reg_wdata_i[DW-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (load_i) cnt_q <= load_cnt_i;
      // completion beats a simultaneous clear
      if (done_set_i)  done_q <= 1'b1;
      else if (clr_w)  done_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CNT)       reg_rdata_o = DW'(cnt_q);
    else if (reg_addr_i == A_STAT) reg_rdata_o[0] = done_q;
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfg_clk_arb.sv
module cfg_clk_arb #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             busy_i,
  input  logic             reg_go_i,
  input  logic [CNT_W-1:0] reg_cnt_i,
  input  logic             seq_go_i,
  input  logic [CNT_W-1:0] seq_cnt_i,
  output logic             go_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             from_seq_o
);
  assign go_o       = !busy_i && (reg_go_i || seq_go_i);
  assign from_seq_o = !reg_go_i && seq_go_i;
  assign cnt_o      = reg_go_i ? reg_cnt_i : seq_cnt_i;
endmodule

// File: rtl/cfg_clk_engine.sv
module cfg_clk_engine #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             from_seq_i,
  output logic             fin_o,
  output logic             seq_done_o,
  output logic             busy_o,
  output logic             dclk_o
);
  localparam int unsigned PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_DIV - 1);

  logic             busy_q, dclk_q, seq_q, seq_done_q;
  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] rem_q;
  logic             ph_end, last_end, zero_go, fin_seq;

  assign ph_end   = (ph_q == PH_LAST);
  assign last_end = busy_q && ph_end && !dclk_q && (rem_q == CNT_W'(1));
  assign zero_go  = go_i && (cnt_i == '0);
  assign fin_o    = last_end || zero_go;
  assign fin_seq  = (last_end && seq_q) || (zero_go && from_seq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dclk_q <= 1'b0;
      seq_q  <= 1'b0;
      ph_q   <= '0;
      rem_q  <= '0;
    end else if (go_i && !zero_go) begin
      busy_q <= 1'b1;
      dclk_q <= 1'b1;
      seq_q  <= from_seq_i;
      ph_q   <= '0;
      rem_q  <= cnt_i;
    end else if (busy_q) begin
      if (ph_end) begin
        ph_q <= '0;
        if (dclk_q) begin
          dclk_q <= 1'b0;
        end else if (rem_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
        end else begin
          rem_q  <= rem_q - CNT_W'(1);
          dclk_q <= 1'b1;
        end
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seq_done_q <= 1'b0;
    else         seq_done_q <= fin_seq;
  end

  assign busy_o     = busy_q;
  assign dclk_o     = dclk_q;
  assign seq_done_o = seq_done_q;
endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst #(
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 32,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_we_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             seq_start_i,
  input  logic [CNT_W-1:0] seq_count_i,
  output logic             seq_done_o,
  output logic             busy_o,
  output logic             dclk_o
);
  logic             go_w, from_seq_w, fin_w, reg_go_w, done_w;
  logic [CNT_W-1:0] go_cnt_w, reg_cnt_w, cnt_w;

  cfg_clk_regif #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_we_i   (reg_we_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .load_i     (go_w),
    .load_cnt_i (go_cnt_w),
    .done_set_i (fin_w),
    .reg_go_o   (reg_go_w),
    .reg_cnt_o  (reg_cnt_w),
    .cnt_o      (cnt_w),
    .done_o     (done_w)
  );

  cfg_clk_arb #(.CNT_W(CNT_W)) u_arb (
    .busy_i    (busy_o),
    .reg_go_i  (reg_go_w),
    .reg_cnt_i (reg_cnt_w),
    .seq_go_i  (seq_start_i),
    .seq_cnt_i (seq_count_i),
    .go_o      (go_w),
    .cnt_o     (go_cnt_w),
    .from_seq_o(from_seq_w)
  );

  cfg_clk_engine #(.CNT_W(CNT_W), .HALF_DIV(HALF_DIV)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go_w),
    .cnt_i     (go_cnt_w),
    .from_seq_i(from_seq_w),
    .fin_o     (fin_w),
    .seq_done_o(seq_done_o),
    .busy_o    (busy_o),
    .dclk_o    (dclk_o)
  );
endmodule

// File: rtl/cfg_clk_burst_chk.sv
module cfg_clk_burst_chk #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    reg_addr_i,
  input logic             reg_we_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic             seq_start_i,
  input logic             seq_done_o,
  input logic             busy_o,
  input logic             dclk_o,
  input logic             done_i,
  input logic [CNT_W-1:0] cnt_i
);
  import cfg_clk_pkg::*;

  logic wr_cnt, wr_clr;
  assign wr_cnt = reg_we_i && (reg_addr_i == AW'(OFS_COUNT));
  assign wr_clr = reg_we_i && (reg_addr_i == AW'(OFS_STATUS)) && reg_wdata_i[0];

  a_r7_dclk_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dclk_o);

  a_r3_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !wr_clr |=> done_i);

  a_r4_clear_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr && !busy_o && !seq_start_i |=> !done_i);

  a_r5_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_cnt && (reg_wdata_i[CNT_W-1:0] == '0) |=> done_i && !busy_o);

  a_r6_count_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cnt_i));

  a_r9_seq_done_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> done_i);

  a_r10_busy_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_i && !dclk_o);

  a_r2_rise_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |-> busy_o);
endmodule

bind cfg_clk_burst cfg_clk_burst_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .seq_start_i(seq_start_i),
  .seq_done_o (seq_done_o),
  .busy_o     (busy_o),
  .dclk_o     (dclk_o),
  .done_i     (done_w),
  .cnt_i      (cnt_w)
);

// File: tb/cfg_clk_burst_test.sv
module cfg_clk_burst_test;
  localparam int AW = 8, DW = 32, CW = 12, H = 2;
  localparam logic [7:0] A_CNT = 8'h08, A_STAT = 8'h0C;

  logic          clk = 0, rst_ni = 0;
  logic [AW-1:0] reg_addr = A_STAT;
  logic          reg_we = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          seq_start = 0;
  logic [CW-1:0] seq_count = '0;
  logic          seq_done, busy, dclk;

  int compared = 0, mismatched = 0;
  int pulses = 0, seq_seen = 0;
  logic prev_dclk = 0;

  // reference model state
  bit m_busy = 0, m_done = 0, m_seq = 0, m_sdone = 0;
  int m_cnt = 0, m_t = 0, m_n = 0;

  always #4 clk = ~clk;

  cfg_clk_burst #(.AW(AW), .DW(DW), .CNT_W(CW), .HALF_DIV(H)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .seq_start_i(seq_start),
    .seq_count_i(seq_count), .seq_done_o(seq_done), .busy_o(busy), .dclk_o(dclk));

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_seq = 0; m_sdone = 0; m_cnt = 0; m_t = 0; m_n = 0;
    end else begin
      bit fin, fseq, cw, clr;
      int n;
      fin = 0; fseq = 0;
      cw  = reg_we && reg_addr == A_CNT;
      clr = reg_we && reg_addr == A_STAT && reg_wdata[0];
      if (m_busy) begin
        m_t++;
        if (m_t == 2 * m_n * H) begin m_busy = 0; fin = 1; fseq = m_seq; end
      end else if (cw || seq_start) begin
        n = cw ? int'(reg_wdata[CW-1:0]) : int'(seq_count);
        m_cnt = n;
        if (n == 0) begin fin = 1; fseq = !cw; end
        else begin m_busy = 1; m_t = 0; m_n = n; m_seq = !cw; end
      end
      if (fin) m_done = 1;
      else if (clr) m_done = 0;
      m_sdone = fseq;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_rdata();
    if (reg_addr == A_CNT) return 32'(m_cnt);
    if (reg_addr == A_STAT) return {31'b0, m_done};
    return '0;
  endfunction

  task automatic tick();
    @(negedge clk);
    check("R2 dclk", {31'b0, dclk}, {31'b0, m_busy && ((m_t / H) % 2 == 0)});
    check("R10 busy", {31'b0, busy}, {31'b0, m_busy});
    check("R9 seq_done", {31'b0, seq_done}, {31'b0, m_sdone});
    check("R8 rdata", reg_rdata, m_rdata());
    if (dclk && !prev_dclk) pulses++;
    if (seq_done) seq_seen++;
    prev_dclk = dclk;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    tick();
    reg_we = 0; reg_addr = A_STAT;
  endtask

  task automatic drain();
    while (busy) tick();
    tick();
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    tick();
    v = reg_rdata;
    reg_addr = A_STAT;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    tick();
    // R12 reset state
    check("R12 dclk", {31'b0, dclk}, 0);
    check("R12 busy", {31'b0, busy}, 0);
    rd(A_STAT, v); check("R12 done", v, 0);
    rd(A_CNT, v);  check("R12 count", v, 0);

    // R1 R3 basic burst of 3
    pulses = 0;
    wr(A_CNT, 3);
    drain();
    check("R1 pulses", pulses, 3);
    rd(A_STAT, v); check("R3 done set", v, 1);
    repeat (5) tick();
    rd(A_STAT, v); check("R3 done sticky", v, 1);

    // R4 clear semantics
    wr(A_STAT, 0);
    rd(A_STAT, v); check("R4 write0 keeps", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R4 write1 clears", v, 0);

    // R5 zero count
    pulses = 0;
    wr(A_CNT, 0);
    check("R5 no busy", {31'b0, busy}, 0);
    rd(A_STAT, v); check("R5 done", v, 1);
    repeat (4) tick();
    check("R5 no pulse", pulses, 0);
    wr(A_STAT, 1);

    // R6 write during burst ignored
    pulses = 0;
    wr(A_CNT, 5);
    repeat (3) tick();
    wr(A_CNT, 9);
    seq_start = 1; seq_count = 7; tick(); seq_start = 0;
    rd(A_CNT, v); check("R6 count kept", v, 5);
    drain();
    check("R6 pulses", pulses, 5);
    check("R6 no seq_done", seq_seen, 0);
    wr(A_STAT, 1);

    // R9 sequencer burst
    pulses = 0; seq_seen = 0;
    seq_start = 1; seq_count = 2; tick(); seq_start = 0;
    drain();
    check("R9 seq pulses", pulses, 2);
    check("R9 seq_done once", seq_seen, 1);
    rd(A_STAT, v); check("R9 done flag", v, 1);
    wr(A_STAT, 1);

    // R9 register write wins same cycle
    pulses = 0; seq_seen = 0;
    seq_start = 1; seq_count = 7;
    wr(A_CNT, 4);
    seq_start = 0;
    drain();
    check("R9 reg wins pulses", pulses, 4);
    check("R9 reg wins no seq_done", seq_seen, 0);
    rd(A_CNT, v); check("R9 reg wins count", v, 4);
    wr(A_STAT, 1);

    // R4 set beats clear: clear asserted through the whole burst
    wr(A_CNT, 2);
    reg_addr = A_STAT; reg_wdata = 1; reg_we = 1;
    while (busy) tick();
    reg_we = 0;
    rd(A_STAT, v); check("R4 set wins", v, 1);
    wr(A_STAT, 1);

    // R9 sequencer zero count
    seq_seen = 0;
    seq_start = 1; seq_count = 0; tick(); seq_start = 0;
    tick();
    check("R9 seq zero done", seq_seen, 1);
    wr(A_STAT, 1);

    // R8 unmapped address
    rd(8'h10, v); check("R8 unmapped", v, 0);
    rd(8'h00, v); check("R8 unmapped 0", v, 0);

    // R11 full 2047 burst
    pulses = 0;
    wr(A_CNT, 32'hFFFF_F7FF);
    rd(A_CNT, v); check("R11 count", v, 2047);
    drain();
    check("R11 pulses", pulses, 2047);
    check("R7 idle low", {31'b0, dclk}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule